// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable pipelined synchronous SRAM. A new command can be issued on every clock edge, and reads and writes may follow each other in any mix without idle cycles. Each word is 36 bits wide and is divided into four 9-bit byte lanes. The bus never needs a turnaround gap. A write's data arrives two enabled cycles after its address, which is the same point at which a read's data leaves the output register. The output drive enable is also held low whenever the data phase belongs to a write.

A command is accepted only while all three chip selects are active. A load/advance input chooses between starting a new access at a fresh address and stepping a 2-bit burst counter. When the counter steps, the access type set at load time is kept. A mode pin latched at load time sets the burst order, either linear or interleaved. When the clock enable is low, the whole pipeline freezes. An asynchronous output enable gates the drive-enable output on top of the synchronous control.

Top module: `zbt_sram`

## Requirements
- R1: After reset is released, `rdata_oe_o` stays low until the first read reaches its data phase.
- R2: A read address captured at enabled edge k produces its word on `rdata_o`, with `rdata_oe_o` high, after enabled edge k+2.
- R3: For a write whose address is captured at enabled edge k, the inputs `wdata_i` and `lane_we_i` are sampled at enabled edge k+2. Lane i is bits [9i+8:9i] and is written only if `lane_we_i[i]` is 1. Every other lane keeps its old contents.
- R4: Reads and writes at arbitrary addresses can be issued on consecutive enabled edges in any order, and every read returns the correct data with no wait state.
- R5: A read returns every write issued before it, including a write issued on the immediately preceding edge to the same address. Partial writes are merged lane by lane.
- R6: While `clk_en_i` is low, no edge changes any state. Outputs hold, the address, command, data and lane inputs are ignored, and a pending write is not committed.
- R7: A load is a deselect unless `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. A deselect writes nothing, and `rdata_oe_o` is low in its data phase.
- R8: `rdata_oe_o` is low during the data phase of every write.
- R9: With `burst_mode_i`=0 at load, the n-th advance (n=1..3) accesses address bits [1:0] equal to (start+n) mod 4. The upper address bits stay unchanged.
- R10: With `burst_mode_i`=1 at load, the n-th advance accesses address bits [1:0] equal to start XOR n.
- R11: When `adv_ld_i`=1, the access type (read, write or deselect) set at load is kept, and `we_i` and the chip selects are ignored.
- R12: While `oe_i` is low, `rdata_oe_o` is low. The read pipeline and `rdata_o` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; low freezes all state |
| ce1_ni | input | 1 | Chip select 1, active low |
| ce2_i | input | 1 | Chip select 2, active high |
| ce3_ni | input | 1 | Chip select 3, active low |
| we_i | input | 1 | 1 = write, 0 = read, sampled at load |
| adv_ld_i | input | 1 | 0 = load new address, 1 = advance burst |
| burst_mode_i | input | 1 | 0 = linear, 1 = interleaved, sampled at load |
| addr_i | input | ADDR_W | Word address |
| lane_we_i | input | LANES | Per-lane write select, sampled in the data phase |
| wdata_i | input | LANES*LANE_W | Write data, sampled in the data phase |
| oe_i | input | 1 | Asynchronous output enable, active high |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rdata_oe_o | output | 1 | Output bus drive enable |

## Verification
The hardest case to reach is a read that trails a write to the same address by exactly one edge. At that moment the write has not yet reached the array, so the read only gets correct data through the per-lane merge. The case is harder still when a clock-enable stall falls between address and data phase. The stimulus repeatedly issues write/read pairs to a handful of addresses with varying lane masks, and it inserts stalls carrying junk command and data values between them. A bench-side model that applies writes in issue order then predicts each read word.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               mode_q;
  op_e                op_q;
  logic [BURST_W-1:0] low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (en_i) begin
      if (!adv_i) begin
        op_q   <= sel_i ? (we_i ? OP_WRITE : OP_READ) : OP_IDLE;
        base_q <= addr_i;
        cnt_q  <= '0;
        mode_q <= mode_i;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // burst order: wrap-add or XOR on the low start bits
  always_comb begin
    if (mode_q) low = base_q[BURST_W-1:0] ^ cnt_q;
    else        low = base_q[BURST_W-1:0] + cnt_q;
  end

  assign op_o   = op_q;
  assign addr_o = {base_q[ADDR_W-1:BURST_W], low};

  p_deselect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i && !sel_i) |=> (op_q == OP_IDLE));
  p_adv_keeps_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> (op_q == $past(op_q)));
  p_burst_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));
  p_load_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> (cnt_q == '0));
  p_stall_burst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(base_q) && $stable(op_q)));
endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_lane_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (wr_i && wr_lane_i[g]) mem[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
        rd_q <= mem[rd_addr_i];   // old contents on a same-edge write
      end
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/zbt_lane_merge.sv
module zbt_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic [LANES*LANE_W-1:0] base_i,
  input  logic [LANES*LANE_W-1:0] fwd_i,
  input  logic [LANES-1:0]        mask_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_o[g*LANE_W +: LANE_W] = mask_i[g] ? fwd_i[g*LANE_W +: LANE_W]
                                                  : base_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_i,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    we_i,
  input  logic                    adv_ld_i,
  input  logic                    burst_mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  op_e               s2_op_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [LANES-1:0]  fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] dq_q;
  logic              rd_oe_q;
  logic              fwd_hit;
  logic              commit;

  assign sel = !ce1_ni && ce2_i && !ce3_ni;

  zbt_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .adv_i  (adv_ld_i),
    .sel_i  (sel),
    .we_i   (we_i),
    .mode_i (burst_mode_i),
    .addr_i (addr_i),
    .op_o   (s1_op),
    .addr_o (s1_addr)
  );

  // write commits in its data phase, the cycle a read would drive the bus
  assign commit = (s2_op_q == OP_WRITE);

  zbt_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .en_i      (clk_en_i),
    .rd_addr_i (s1_addr),
    .wr_i      (commit),
    .wr_addr_i (s2_addr_q),
    .wr_lane_i (lane_we_i),
    .wr_data_i (wdata_i),
    .rd_data_o (arr_data)
  );

  // array read and older write commit share an edge: capture the write lanes
  assign fwd_hit = (s1_op == OP_READ) && commit && (s1_addr == s2_addr_q);

  zbt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .base_i (arr_data),
    .fwd_i  (fwd_data_q),
    .mask_i (fwd_mask_q),
    .data_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_op_q    <= OP_IDLE;
      s2_addr_q  <= '0;
      fwd_mask_q <= '0;
      fwd_data_q <= '0;
      rd_oe_q    <= 1'b0;
      dq_q       <= '0;
    end else if (clk_en_i) begin
      s2_op_q    <= s1_op;
      s2_addr_q  <= s1_addr;
      fwd_mask_q <= fwd_hit ? lane_we_i : '0;
      fwd_data_q <= wdata_i;
      rd_oe_q    <= (s2_op_q == OP_READ);
      if (s2_op_q == OP_READ) dq_q <= merged;
    end
  end

  assign rdata_o    = dq_q;
  assign rdata_oe_o = rd_oe_q && oe_i;

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(dq_q) && $stable(rd_oe_q) && $stable(s2_op_q)));
  p_write_phase_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s2_op_q == OP_WRITE) |=> !rd_oe_q);
  p_read_phase_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s2_op_q == OP_READ) |=> rd_oe_q);
  p_fwd_read_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s1_op != OP_READ) |=> (fwd_mask_q == '0));
  p_idle_phase_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s2_op_q == OP_IDLE) |=> !rd_oe_q);
endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b1;
  logic        ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic        we_i = 1'b0, adv_ld_i = 1'b0, burst_mode_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [3:0]  lane_we_i = '0;
  logic [35:0] wdata_i = '0;
  logic        oe_i = 1'b1;
  logic [35:0] rdata_o;
  logic        rdata_oe_o;

  always #2 clk_i = ~clk_i;

  zbt_sram dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i),
    .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
    .we_i(we_i), .adv_ld_i(adv_ld_i), .burst_mode_i(burst_mode_i),
    .addr_i(addr_i), .lane_we_i(lane_we_i), .wdata_i(wdata_i), .oe_i(oe_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  int n_chk = 0, n_bad = 0, ncmd = 0;
  bit done = 0;
  string tag = "R1";
  logic [35:0] ref_mem [64];
  int          op_h  [256];
  logic [5:0]  addr_h[256];
  logic [35:0] wd_h  [256];
  logic [3:0]  mk_h  [256];
  logic [35:0] exp_h [256];
  int          m_op = 0;
  logic [5:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  bit          m_mode = 0;
  bit          use_force = 0;
  logic [3:0]  force_mask = 4'hf;

  task automatic report(input bit ok, input string t, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // output after enabled edge n belongs to command n-2
  task automatic check_cmd(input int k, input bit oe);
    if (k < 0) begin
      report(rdata_oe_o === 1'b0, "R1", "oe before first data", {63'd0, rdata_oe_o}, 64'd0);
    end else if (op_h[k%256] == 1) begin
      if (oe) report(rdata_oe_o === 1'b1, tag, "read oe", {63'd0, rdata_oe_o}, 64'd1);
      else    report(rdata_oe_o === 1'b0, "R12", "oe gated", {63'd0, rdata_oe_o}, 64'd0);
      report(rdata_o === exp_h[k%256], oe ? tag : "R12", "read data",
             {28'd0, rdata_o}, {28'd0, exp_h[k%256]});
    end else if (op_h[k%256] == 2) begin
      report(rdata_oe_o === 1'b0, "R8", "write phase oe", {63'd0, rdata_oe_o}, 64'd0);
    end else begin
      report(rdata_oe_o === 1'b0, "R7", "deselect phase oe", {63'd0, rdata_oe_o}, 64'd0);
    end
  endtask

  task automatic tick(input bit en, input bit adv, input bit c1n, input bit c2, input bit c3n,
                      input bit we, input logic [5:0] a, input bit md, input bit oe);
    logic [35:0] prev_d;
    logic        prev_oe;
    logic [5:0]  ea;
    logic [35:0] wd;
    logic [3:0]  mk;
    longint      v;
    int          n;
    prev_d = rdata_o;
    prev_oe = rdata_oe_o;
    n = ncmd;
    clk_en_i = en; adv_ld_i = adv; ce1_ni = c1n; ce2_i = c2; ce3_ni = c3n;
    we_i = we; addr_i = a; burst_mode_i = md; oe_i = oe;
    wdata_i = 36'hA5A5A5A5A; lane_we_i = 4'hf;
    if (en) begin
      if (!adv) begin
        m_op = (!c1n && c2 && !c3n) ? (we ? 2 : 1) : 0;
        m_base = a; m_cnt = 2'd0; m_mode = md;
      end else m_cnt = m_cnt + 2'd1;
      ea = {m_base[5:2], m_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      op_h[n%256] = m_op;
      addr_h[n%256] = ea;
      if (m_op == 2) begin
        v  = longint'(n) * 64'd2654435761 + 64'd977;
        wd = v[35:0];
        mk = use_force ? force_mask : 4'((n * 7 + 1) % 16);
        wd_h[n%256] = wd;
        mk_h[n%256] = mk;
        for (int l = 0; l < 4; l++) if (mk[l]) ref_mem[ea][l*9 +: 9] = wd[l*9 +: 9];
      end else if (m_op == 1) exp_h[n%256] = ref_mem[ea];
      if (n >= 2 && op_h[(n-2)%256] == 2) begin
        wdata_i = wd_h[(n-2)%256];
        lane_we_i = mk_h[(n-2)%256];
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    if (en) begin
      ncmd++;
      check_cmd(n - 2, oe);
    end else begin
      report(rdata_o === prev_d, "R6", "stall data hold", {28'd0, rdata_o}, {28'd0, prev_d});
      report(rdata_oe_o === prev_oe, "R6", "stall oe hold", {63'd0, rdata_oe_o}, {63'd0, prev_oe});
    end
  endtask

  task automatic wr(input logic [5:0] a);  tick(1, 0, 0, 1, 0, 1, a, 0, 1); endtask
  task automatic rd(input logic [5:0] a);  tick(1, 0, 0, 1, 0, 0, a, 0, 1); endtask
  task automatic nop();                    tick(1, 0, 1, 0, 1, 0, 6'd0, 0, 1); endtask

  initial begin
    for (int i = 0; i < 256; i++) op_h[i] = 0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    report(rdata_oe_o === 1'b0, "R1", "oe in reset", {63'd0, rdata_oe_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    report(rdata_oe_o === 1'b0, "R1", "oe after reset", {63'd0, rdata_oe_o}, 64'd0);

    // fill every word with full lanes
    tag = "R3"; use_force = 1; force_mask = 4'hf;
    for (int a = 0; a < 64; a++) wr(6'(a));
    tag = "R2";
    for (int a = 0; a < 64; a++) rd(6'(a));
    // every lane mask
    tag = "R3";
    for (int m = 0; m < 16; m++) begin force_mask = 4'(m); wr(6'(m)); end
    for (int a = 0; a < 16; a++) rd(6'(a));
    // write immediately followed by read of same word, varied masks
    tag = "R5"; use_force = 0;
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) wr(6'((i / 2) % 8)); else rd(6'((i / 2) % 8));
    end
    // arbitrary mix, no gaps
    tag = "R4";
    for (int i = 0; i < 96; i++) begin
      int h;
      h = (i * 13 + 5) % 17;
      if (h % 3 == 0) wr(6'(h % 8)); else if (h % 3 == 1) rd(6'((h + i) % 8)); else nop();
    end
    // chip select combinations; only 0/1/0 may write
    tag = "R7"; use_force = 1; force_mask = 4'hf;
    for (int c = 0; c < 8; c++) tick(1, 0, c[0], c[1], c[2], 1, 6'(20 + c), 0, 1);
    for (int c = 0; c < 8; c++) rd(6'(20 + c));
    // linear bursts
    tag = "R9";
    for (int s = 0; s < 4; s++) begin
      tick(1, 0, 0, 1, 0, 1, 6'(32 + s), 0, 1);
      for (int b = 0; b < 3; b++) tick(1, 1, 0, 1, 0, 1, 6'd0, 0, 1);
      tick(1, 0, 0, 1, 0, 0, 6'(32 + s), 0, 1);
      for (int b = 0; b < 3; b++) tick(1, 1, 0, 1, 0, 0, 6'd0, 0, 1);
    end
    for (int a = 32; a < 36; a++) rd(6'(a));
    // interleaved bursts
    tag = "R10";
    for (int s = 0; s < 4; s++) begin
      tick(1, 0, 0, 1, 0, 1, 6'(40 + s), 1, 1);
      for (int b = 0; b < 3; b++) tick(1, 1, 0, 1, 0, 1, 6'd0, 0, 1);
      tick(1, 0, 0, 1, 0, 0, 6'(40 + s), 1, 1);
      for (int b = 0; b < 3; b++) tick(1, 1, 0, 1, 0, 0, 6'd0, 0, 1);
    end
    for (int a = 40; a < 44; a++) rd(6'(a));
    // advance ignores selects and write enable
    tag = "R11"; use_force = 0;
    tick(1, 0, 0, 1, 0, 1, 6'd49, 0, 1);
    tick(1, 1, 1, 0, 1, 0, 6'd7, 1, 1);
    tick(1, 1, 1, 1, 1, 0, 6'd3, 1, 1);
    tick(1, 1, 0, 0, 0, 0, 6'd9, 0, 1);
    tick(1, 0, 0, 1, 0, 0, 6'd50, 0, 1);
    tick(1, 1, 1, 0, 1, 1, 6'd0, 0, 1);
    tick(1, 0, 1, 0, 1, 1, 6'd52, 0, 1);
    tick(1, 1, 0, 1, 0, 1, 6'd53, 0, 1);
    for (int a = 48; a < 54; a++) rd(6'(a));
    // stalls with junk inputs inside live traffic
    tag = "R5";
    for (int i = 0; i < 36; i++) begin
      if (i % 3 == 1) tick(0, i[2], i[0], i[1], i[3], ~i[0], 6'(i), i[1], 1);
      else if (i % 2 == 0) wr(6'(56 + i % 4));
      else rd(6'(56 + i % 4));
    end
    // asynchronous output enable
    for (int i = 0; i < 12; i++) tick(1, 0, 0, 1, 0, 0, 6'(i), 0, i[0]);
    tick(1, 0, 1, 0, 1, 0, 6'd0, 0, 0);
    tick(1, 0, 1, 0, 1, 0, 6'd0, 0, 0);
    nop(); nop(); nop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule